// File: doc/BRIEF.md
# PC A20 Gate Controller

This block is a small programmed-I/O peripheral. It sits where the processor's physical address leaves the core. It decides whether address line 20 is passed through or forced low. Forcing it low reproduces the one-megabyte wrap-around of early real-mode machines.

Software can open the gate in two ways, and each has its own state:
- **Fast control byte.** Byte-wide writes to the system control port at I/O address 0x92 set this byte, and reads of that port return it.
- **Keyboard-controller path.** Write the command byte 0xD1 to the controller command port at 0x64. The next byte written to the data port at 0x60 then loads the controller's A20 output.

The gate is open when either source asks for it. The address path is purely combinational, so the mask adds no latency to bus cycles.

Top module: `a20_gate`

## Requirements
- R1: After synchronous reset both enable sources are clear. `a20_en` is 0, and a read of port 0x92 returns 0x00.
- R2: A write to port 0x92 stores the full data byte. A later read of port 0x92 (io_valid=1, io_write=0) returns that byte on `io_rdata` in the same cycle.
- R3: Bit 1 of the port 0x92 byte is the fast enable. From the cycle after the write, `a20_en` is 1 when that bit is 1 and no other source is set.
- R4: Writing 0xD1 to port 0x64 arms the controller. The next write to port 0x60 sets the controller enable to bit 1 of its data byte, from the cycle after that write.
- R5: A write to port 0x60 that is not armed leaves the controller enable unchanged.
- R6: One armed data write uses up the arming, so a second write to 0x60 is ignored. A write of any byte other than 0xD1 to port 0x64 disarms the controller.
- R7: `a20_en` is the logical OR of the fast enable and the controller enable.
- R8: When `a20_en` is 0, `addr_out` equals `addr_in` with bit 20 cleared. When `a20_en` is 1, `addr_out` equals `addr_in`. All other bits always pass unchanged, combinationally.
- R9: Reads never change state. Writes to other port numbers have no effect. `io_rdata` is 0x00 except during a read of port 0x92.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_valid | input | 1 | I/O access strobe, one cycle per access |
| io_write | input | 1 | 1 = OUT (write), 0 = IN (read) |
| io_port | input | 16 | I/O port number |
| io_wdata | input | 8 | Write data byte |
| io_rdata | output | 8 | Read data byte |
| addr_in | input | ADDR_W | Physical address from the core |
| addr_out | output | ADDR_W | Address after A20 masking |
| a20_en | output | 1 | Combined A20 enable |

## Verification
The bench uses the default 32-bit address width. This places bit 20 well inside the word, with eleven bits above it and twenty below. Random addresses therefore show that only the masked bit is touched, on both sides of it.

Random port traffic is weighted toward the three decoded ports and toward the 0xD1 command. Arm, disarm, consume and ignore sequences therefore occur many times and interleave with fast-port writes.

// File: rtl/a20_pkg.sv
package a20_pkg;
    localparam int PORT_W = 16;
    localparam int DATA_W = 8;
    localparam logic [PORT_W-1:0] PORT_SYSCTL   = 16'h0092;
    localparam logic [PORT_W-1:0] PORT_KBC_CMD  = 16'h0064;
    localparam logic [PORT_W-1:0] PORT_KBC_DATA = 16'h0060;
    localparam logic [DATA_W-1:0] CMD_LOAD_OUT  = 8'hD1;
    localparam int GATE_BIT = 1;

    typedef enum logic [1:0] {
        SEL_NONE,
        SEL_SYSCTL,
        SEL_KCMD,
        SEL_KDATA
    } io_sel_e;

    typedef struct packed {
        logic              wr;
        logic              rd;
        io_sel_e           sel;
        logic [DATA_W-1:0] data;
    } io_req_t;

    function automatic io_sel_e decode_port(input logic [PORT_W-1:0] p);
        if (p == PORT_SYSCTL)        return SEL_SYSCTL;
        else if (p == PORT_KBC_CMD)  return SEL_KCMD;
        else if (p == PORT_KBC_DATA) return SEL_KDATA;
        else                         return SEL_NONE;
    endfunction
endpackage

// File: rtl/a20_io_decode.sv
module a20_io_decode
    import a20_pkg::*;
(
    input  logic              io_valid,
    input  logic              io_write,
    input  logic [PORT_W-1:0] io_port,
    input  logic [DATA_W-1:0] io_wdata,
    output io_req_t           req
);
    always_comb begin
        req.wr   = io_valid & io_write;
        req.rd   = io_valid & ~io_write;
        req.sel  = decode_port(io_port);
        req.data = io_wdata;
    end
endmodule

// File: rtl/a20_fast_reg.sv
module a20_fast_reg
    import a20_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  io_req_t           req,
    output logic [DATA_W-1:0] value_q,
    output logic              fast_en
);
    always_ff @(posedge clk) begin
        if (rst)
            value_q <= '0;
        else if (req.wr && req.sel == SEL_SYSCTL)
            value_q <= req.data;
    end

    assign fast_en = value_q[GATE_BIT];
endmodule

// File: rtl/a20_kbc_path.sv
module a20_kbc_path
    import a20_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  io_req_t req,
    output logic    armed_q,
    output logic    kbc_en_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            armed_q  <= 1'b0;
            kbc_en_q <= 1'b0;
        end else if (req.wr) begin
            case (req.sel)
                SEL_KCMD: armed_q <= (req.data == CMD_LOAD_OUT);
                SEL_KDATA: begin
                    if (armed_q)
                        kbc_en_q <= req.data[GATE_BIT];
                    armed_q <= 1'b0;
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/a20_addr_mask.sv
module a20_addr_mask #(
    parameter int ADDR_W   = 32,
    parameter int MASK_BIT = 20
) (
    input  logic              gate_en,
    input  logic [ADDR_W-1:0] addr_in,
    output logic [ADDR_W-1:0] addr_out
);
    for (genvar i = 0; i < ADDR_W; i++) begin : g_bit
        if (i == MASK_BIT) begin : g_gated
            assign addr_out[i] = addr_in[i] & gate_en;
        end else begin : g_pass
            assign addr_out[i] = addr_in[i];
        end
    end
endmodule

// File: rtl/a20_gate.sv
module a20_gate
    import a20_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              io_valid,
    input  logic              io_write,
    input  logic [15:0]       io_port,
    input  logic [7:0]        io_wdata,
    output logic [7:0]        io_rdata,
    input  logic [ADDR_W-1:0] addr_in,
    output logic [ADDR_W-1:0] addr_out,
    output logic              a20_en
);
    localparam int MASK_BIT = 20;

    io_req_t           req;
    logic [DATA_W-1:0] fast_q;
    logic              fast_en;
    logic              kbc_armed;
    logic              kbc_en;

    a20_io_decode u_dec (
        .io_valid (io_valid),
        .io_write (io_write),
        .io_port  (io_port),
        .io_wdata (io_wdata),
        .req      (req)
    );

    a20_fast_reg u_fast (
        .clk     (clk),
        .rst     (rst),
        .req     (req),
        .value_q (fast_q),
        .fast_en (fast_en)
    );

    a20_kbc_path u_kbc (
        .clk      (clk),
        .rst      (rst),
        .req      (req),
        .armed_q  (kbc_armed),
        .kbc_en_q (kbc_en)
    );

    assign a20_en   = fast_en | kbc_en;
    assign io_rdata = (req.rd && req.sel == SEL_SYSCTL) ? fast_q : '0;

    a20_addr_mask #(.ADDR_W(ADDR_W), .MASK_BIT(MASK_BIT)) u_mask (
        .gate_en  (a20_en),
        .addr_in  (addr_in),
        .addr_out (addr_out)
    );
endmodule

// File: rtl/a20_gate_chk.sv
module a20_gate_chk
    import a20_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              io_valid,
    input logic              io_write,
    input logic [15:0]       io_port,
    input logic [7:0]        io_wdata,
    input logic [ADDR_W-1:0] addr_in,
    input logic [ADDR_W-1:0] addr_out,
    input logic              a20_en,
    input logic [7:0]        fast_q,
    input logic              kbc_armed,
    input logic              kbc_en
);
    localparam logic [ADDR_W-1:0] BIT20 = ADDR_W'(1) << 20;

    logic wr_sys, wr_cmd, wr_dat;
    assign wr_sys = io_valid && io_write && io_port == PORT_SYSCTL;
    assign wr_cmd = io_valid && io_write && io_port == PORT_KBC_CMD;
    assign wr_dat = io_valid && io_write && io_port == PORT_KBC_DATA;

    assert_reset_clear_R1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (!a20_en && fast_q == 8'h00 && !kbc_armed));

    assert_fast_store_R2: assert property (@(posedge clk) disable iff (rst)
        wr_sys |=> fast_q == $past(io_wdata));

    assert_fast_open_R3: assert property (@(posedge clk) disable iff (rst)
        (wr_sys && io_wdata[1]) |=> a20_en);

    assert_arm_R4: assert property (@(posedge clk) disable iff (rst)
        (wr_cmd && io_wdata == CMD_LOAD_OUT) |=> kbc_armed);

    assert_load_R4: assert property (@(posedge clk) disable iff (rst)
        (wr_dat && kbc_armed) |=> (kbc_en == $past(io_wdata[1]) && !kbc_armed));

    assert_unarmed_ignored_R5: assert property (@(posedge clk) disable iff (rst)
        (wr_dat && !kbc_armed) |=> $stable(kbc_en));

    assert_disarm_R6: assert property (@(posedge clk) disable iff (rst)
        (wr_cmd && io_wdata != CMD_LOAD_OUT) |=> !kbc_armed);

    assert_mask_closed_R8: assert property (@(posedge clk) disable iff (rst)
        !a20_en |-> (!addr_out[20] && (addr_out | BIT20) == (addr_in | BIT20)));

    assert_mask_open_R8: assert property (@(posedge clk) disable iff (rst)
        a20_en |-> addr_out == addr_in);

    assert_read_no_effect_R9: assert property (@(posedge clk) disable iff (rst)
        (io_valid && !io_write) |=> ($stable(fast_q) && $stable(kbc_en) && $stable(kbc_armed)));
endmodule

bind a20_gate a20_gate_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .io_valid  (io_valid),
    .io_write  (io_write),
    .io_port   (io_port),
    .io_wdata  (io_wdata),
    .addr_in   (addr_in),
    .addr_out  (addr_out),
    .a20_en    (a20_en),
    .fast_q    (fast_q),
    .kbc_armed (kbc_armed),
    .kbc_en    (kbc_en)
);

// File: tb/tb_a20_gate.sv
`timescale 1ns/1ps
module tb_a20_gate;
    localparam int ADDR_W = 32;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              io_valid = 1'b0;
    logic              io_write = 1'b0;
    logic [15:0]       io_port = '0;
    logic [7:0]        io_wdata = '0;
    logic [7:0]        io_rdata;
    logic [ADDR_W-1:0] addr_in = '0;
    logic [ADDR_W-1:0] addr_out;
    logic              a20_en;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // reference model state
    logic [7:0] m_fast;
    logic       m_armed;
    logic       m_kbc;

    always #4 clk = ~clk;

    a20_gate #(.ADDR_W(ADDR_W)) dut (
        .clk(clk), .rst(rst), .io_valid(io_valid), .io_write(io_write),
        .io_port(io_port), .io_wdata(io_wdata), .io_rdata(io_rdata),
        .addr_in(addr_in), .addr_out(addr_out), .a20_en(a20_en)
    );

    function automatic logic exp_en();
        return m_fast[1] | m_kbc;
    endfunction

    function automatic logic [ADDR_W-1:0] exp_addr(input logic [ADDR_W-1:0] a);
        logic [ADDR_W-1:0] r;
        r = a;
        if (!exp_en()) r[20] = 1'b0;
        return r;
    endfunction

    task automatic chk(input string tag, input logic [ADDR_W-1:0] act,
                       input logic [ADDR_W-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // one I/O access; called just after a negedge
    task automatic io(input bit wr, input logic [15:0] port, input logic [7:0] data,
                      input string tag);
        io_valid = 1'b1;
        io_write = wr;
        io_port  = port;
        io_wdata = data;
        #1;
        if (!wr)
            chk(tag, ADDR_W'(io_rdata), ADDR_W'((port == 16'h0092) ? m_fast : 8'h00));
        @(posedge clk);
        if (wr) begin
            if (port == 16'h0092) m_fast = data;
            else if (port == 16'h0064) m_armed = (data == 8'hD1);
            else if (port == 16'h0060) begin
                if (m_armed) m_kbc = data[1];
                m_armed = 1'b0;
            end
        end
        @(negedge clk);
        io_valid = 1'b0;
        io_write = 1'b0;
    endtask

    task automatic chk_out(input string en_tag, input logic [ADDR_W-1:0] a);
        addr_in = a;
        #1;
        chk(en_tag, ADDR_W'(a20_en), ADDR_W'(exp_en()));
        chk("R8", addr_out, exp_addr(a));
    endtask

    task automatic rd92(input string tag);
        io(1'b0, 16'h0092, 8'h00, tag);
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [ADDR_W-1:0] a;
        void'($urandom(32'h0A20_5EED));
        m_fast = 8'h00; m_armed = 1'b0; m_kbc = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        chk_out("R1", 32'hFFFF_FFFF);
        rd92("R1");

        // R2, R3: fast byte
        io(1'b1, 16'h0092, 8'hA6, "R2");
        rd92("R2");
        chk_out("R3", 32'h0010_0000);
        io(1'b1, 16'h0092, 8'h5D, "R2");
        rd92("R2");
        chk_out("R3", 32'h0013_4567);

        // R4: controller path
        io(1'b1, 16'h0064, 8'hD1, "R4");
        io(1'b1, 16'h0060, 8'h02, "R4");
        chk_out("R4", 32'h7FF0_0001);
        // R7: both on, then fast off leaves enabled
        io(1'b1, 16'h0092, 8'h02, "R7");
        chk_out("R7", 32'h0010_0000);
        io(1'b1, 16'h0092, 8'h00, "R7");
        chk_out("R7", 32'h0010_0000);

        // R6: arming consumed by one write
        io(1'b1, 16'h0064, 8'hD1, "R6");
        io(1'b1, 16'h0060, 8'h00, "R6");
        chk_out("R6", 32'h0010_0000);
        io(1'b1, 16'h0060, 8'h02, "R6");
        chk_out("R6", 32'h0010_0000);

        // R5: unarmed data write ignored
        io(1'b1, 16'h0060, 8'hFF, "R5");
        chk_out("R5", 32'hFFFF_FFFF);

        // R6: other command disarms
        io(1'b1, 16'h0064, 8'hD1, "R6");
        io(1'b1, 16'h0064, 8'hAD, "R6");
        io(1'b1, 16'h0060, 8'h02, "R6");
        chk_out("R6", 32'h0010_0000);

        // R9: writes elsewhere and reads change nothing
        io(1'b1, 16'h0093, 8'h02, "R9");
        io(1'b1, 16'h0192, 8'h02, "R9");
        io(1'b0, 16'h0060, 8'h00, "R9");
        io(1'b0, 16'h0064, 8'h00, "R9");
        chk_out("R9", 32'h0010_0000);
        rd92("R9");

        // random traffic
        for (int i = 0; i < 400; i++) begin
            int unsigned pick;
            logic [15:0] p;
            logic [7:0]  d;
            pick = $urandom_range(0, 9);
            case (pick)
                0, 1, 2: p = 16'h0092;
                3, 4, 5: p = 16'h0064;
                6, 7, 8: p = 16'h0060;
                default: p = 16'($urandom);
            endcase
            d = ($urandom_range(0, 2) == 0) ? 8'hD1 : 8'($urandom);
            io($urandom_range(0, 3) != 0, p, d, "R9");
            a = ADDR_W'($urandom);
            chk_out("R7", a);
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule